// File: doc/BRIEF.md
# Program Sequencer and Instruction Decoder

This block is the control heart of a small 4-bit machine. It holds an 8-bit program counter, fetches one 12-bit instruction word per cycle from an external program memory, and decodes it. The top nibble picks the instruction class. The block either hands a 4-bit function code to the arithmetic unit or to the register file with a one-cycle enable, or it does the work itself. The work it does itself covers waiting, jumps (with or without a condition), comparing two registers through two read ports, halting (with or without a condition) and driving four indicator lamps.

The block does not hold the data registers. It names them on two 2-bit read-index outputs and takes their 4-bit values back on the same cycle. The program memory is also outside and is read combinationally at the program counter. After reset the sequencer is halted. A pulse on the start input sends the program counter to 0 and begins execution on the next cycle. The condition flag and the lamps keep their values across a start; only reset clears them.

Top module: `insn_sequencer`

## Requirements
- R1: After reset the program counter is 0, the block is halted, the condition flag is 0, all lamps are off, and both function enables are low.
- R2: A start pulse sets the program counter to 0 and the run state to 1 on the next edge; no instruction executes in the start cycle. While halted, the program counter holds and no enable is raised.
- R3: Class 0 (instruction bits 11:8 = 0) raises the arithmetic enable with the low nibble as its function code, and class 1 raises the register-file enable with the low nibble as its command code, in the same cycle the word is presented. The two enables are never high together.
- R4: Class 2 and the undefined classes 4, 10, 11, 12, 13, 14 and 15 change nothing except that the program counter advances by one.
- R5: Class 3 loads bits 7:0 into the program counter. A non-jumping instruction at address 255 is followed by address 0.
- R6: Class 5 jumps to bits 7:0 only when the flag is 1, and class 6 only when the flag is 0; otherwise the counter advances by one.
- R7: Class 7 compares register[bits 5:4] (operand A) with register[bits 7:6] (operand B) as unsigned values. It writes the flag with A>B, A<B or A==B when bits 3:0 are 1, 2 or 3. Any other low nibble leaves the flag unchanged.
- R8: With bits 11:8 = 8 and bits 7:4 = 0, the block halts. With bits 7:4 = 1, 2 or 3, it halts only if register[bits 1:0] is greater than, less than or equal to register[bits 3:2]. A halt leaves the program counter on the halting instruction.
- R9: With bits 11:8 = 9 and bits 7:4 in 0 to 3, the lamp index is loaded from the low two bits of register[bits 5:4]. Bits 7:4 = 4 turns the indexed lamp on, 5 turns it off, and 6 copies that lamp's state into the flag. Lamp i drives lamps_o[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse: counter to 0, enter run state |
| imem_addr_o | output | 8 | Program counter, address of program memory |
| imem_data_i | input | 12 | Instruction word at imem_addr_o |
| alu_en_o | output | 1 | Arithmetic function enable |
| alu_fn_o | output | 4 | Arithmetic function code |
| rf_en_o | output | 1 | Register-file command enable |
| rf_cmd_o | output | 4 | Register-file command code |
| rd_a_idx_o | output | 2 | Read index for operand A |
| rd_a_data_i | input | 4 | Register value for operand A |
| rd_b_idx_o | output | 2 | Read index for operand B |
| rd_b_data_i | input | 4 | Register value for operand B |
| cond_o | output | 1 | Condition flag |
| running_o | output | 1 | Run state |
| lamps_o | output | 4 | Lamp states |

## Verification
The hardest states to reach are the program-counter wrap and flag-gated branches with the flag in a known state. Reaching the wrap means jumping to address 255 and stepping from there. Each branch test first sets the flag with a compare on register values that the bench chooses. The bench models the register file and program memory itself. It then makes the operand pairs asymmetric, with one register at 15 and the other at 1. With that choice, a swapped index order or a signed comparison gives a different flag. The lamp test query is run both before and after a lamp is cleared, so that a stale index or lamp shows up in the flag.

// File: rtl/insn_seq_pkg.sv
package insn_seq_pkg;
  localparam int NIB_W  = 4;
  localparam int INSN_W = 3 * NIB_W;
  localparam int ADDR_W = 2 * NIB_W;
  localparam int IDX_W  = 2;

  typedef enum logic [NIB_W-1:0] {
    OP_ALU  = 4'h0,
    OP_RF   = 4'h1,
    OP_WAIT = 4'h2,
    OP_JMP  = 4'h3,
    OP_JT   = 4'h5,
    OP_JF   = 4'h6,
    OP_CMP  = 4'h7,
    OP_HALT = 4'h8,
    OP_LAMP = 4'h9
  } op_e;

  typedef enum logic [1:0] {
    REL_NONE = 2'd0,
    REL_GT   = 2'd1,
    REL_LT   = 2'd2,
    REL_EQ   = 2'd3
  } rel_e;

  typedef struct packed {
    logic             alu_en;
    logic             rf_en;
    logic             is_wait;
    logic             jmp_any;
    logic             jmp_set;
    logic             jmp_clr;
    logic             cmp_wr;
    logic             halt_any;
    logic             halt_rel;
    logic             lamp_sel;
    logic             lamp_on;
    logic             lamp_off;
    logic             lamp_test;
    rel_e             rel;
    logic [IDX_W-1:0] a_idx;
    logic [IDX_W-1:0] b_idx;
  } dec_t;
endpackage

// File: rtl/insn_seq_decode.sv
module insn_seq_decode
  import insn_seq_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);
  logic [NIB_W-1:0] op_nib, mid_nib, low_nib;

  assign op_nib  = insn_i[3*NIB_W-1:2*NIB_W];
  assign mid_nib = insn_i[2*NIB_W-1:NIB_W];
  assign low_nib = insn_i[NIB_W-1:0];

  always_comb begin
    dec_o = '0;
    case (op_e'(op_nib))
      OP_ALU:  dec_o.alu_en = 1'b1;
      OP_RF:   dec_o.rf_en  = 1'b1;
      OP_WAIT: dec_o.is_wait = 1'b1;
      OP_JMP:  dec_o.jmp_any = 1'b1;
      OP_JT:   dec_o.jmp_set = 1'b1;
      OP_JF:   dec_o.jmp_clr = 1'b1;
      OP_CMP: begin
        dec_o.a_idx = mid_nib[IDX_W-1:0];
        dec_o.b_idx = mid_nib[2*IDX_W-1:IDX_W];
        if (low_nib[3:2] == 2'b00 && low_nib[1:0] != 2'b00) begin
          dec_o.cmp_wr = 1'b1;
          dec_o.rel    = rel_e'(low_nib[1:0]);
        end
      end
      OP_HALT: begin
        dec_o.a_idx = low_nib[IDX_W-1:0];
        dec_o.b_idx = low_nib[2*IDX_W-1:IDX_W];
        if (mid_nib == 4'h0) begin
          dec_o.halt_any = 1'b1;
        end else if (mid_nib[3:2] == 2'b00) begin
          dec_o.halt_rel = 1'b1;
          dec_o.rel      = rel_e'(mid_nib[1:0]);
        end
      end
      OP_LAMP: begin
        dec_o.a_idx = mid_nib[IDX_W-1:0];
        case (mid_nib)
          4'h0, 4'h1, 4'h2, 4'h3: dec_o.lamp_sel = 1'b1;
          4'h4: dec_o.lamp_on   = 1'b1;
          4'h5: dec_o.lamp_off  = 1'b1;
          4'h6: dec_o.lamp_test = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/insn_seq_cmp.sv
module insn_seq_cmp
  import insn_seq_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  rel_e              rel_i,
  output logic              hit_o
);
  always_comb begin
    case (rel_i)
      REL_GT:  hit_o = (a_i > b_i);
      REL_LT:  hit_o = (a_i < b_i);
      REL_EQ:  hit_o = (a_i == b_i);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/insn_seq_pc.sv
module insn_seq_pc
  import insn_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              exec_i,
  input  logic              jump_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic              halt_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              run_o
);
  logic [ADDR_W-1:0] pc_q, pc_nxt;
  logic              run_q, run_nxt;
  logic              upd_en;

  assign upd_en = start_i | exec_i;

  always_comb begin
    pc_nxt  = pc_q;
    run_nxt = run_q;
    if (start_i) begin
      pc_nxt  = '0;
      run_nxt = 1'b1;
    end else if (exec_i) begin
      if (halt_i)      run_nxt = 1'b0;
      else if (jump_i) pc_nxt  = tgt_i;
      else             pc_nxt  = pc_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      run_q <= 1'b0;
    end else if (upd_en) begin
      pc_q  <= pc_nxt;
      run_q <= run_nxt;
    end
  end

  assign pc_o  = pc_q;
  assign run_o = run_q;

  AST_START_ENTERS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (pc_q == '0) && run_q); // R2
  AST_IDLE_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> $stable(pc_q) && !run_q); // R2
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && halt_i && !start_i) |=> !run_q && $stable(pc_q)); // R8
endmodule

// File: rtl/insn_seq_lamps.sv
module insn_seq_lamps #(
  parameter int NLAMP  = 4,
  parameter int LIDX_W = $clog2(NLAMP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_en_i,
  input  logic [LIDX_W-1:0] sel_val_i,
  input  logic              on_en_i,
  input  logic              off_en_i,
  output logic [NLAMP-1:0]  lamps_o,
  output logic              cur_o
);
  logic [LIDX_W-1:0] idx_q;
  logic [NLAMP-1:0]  lamp_q, lamp_nxt;
  logic              lamp_en;

  assign lamp_en = on_en_i | off_en_i;

  for (genvar gi = 0; gi < NLAMP; gi++) begin : g_lamp
    always_comb begin
      lamp_nxt[gi] = lamp_q[gi];
      if (idx_q == LIDX_W'(gi)) begin
        if (on_en_i)       lamp_nxt[gi] = 1'b1;
        else if (off_en_i) lamp_nxt[gi] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (sel_en_i) idx_q <= sel_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lamp_q <= '0;
    else if (lamp_en) lamp_q <= lamp_nxt;
  end

  assign lamps_o = lamp_q;
  assign cur_o   = lamp_q[idx_q];

  AST_LAMP_ON: assert property (@(posedge clk) disable iff (!rst_n)
    on_en_i |=> lamp_q[$past(idx_q)]); // R9
  AST_LAMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (off_en_i && !on_en_i) |=> !lamp_q[$past(idx_q)]); // R9
  AST_LAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_en_i && !off_en_i) |=> $stable(lamp_q)); // R9
endmodule

// File: rtl/insn_sequencer.sv
module insn_sequencer
  import insn_seq_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int NLAMP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [ADDR_W-1:0] imem_addr_o,
  input  logic [INSN_W-1:0] imem_data_i,
  output logic              alu_en_o,
  output logic [NIB_W-1:0]  alu_fn_o,
  output logic              rf_en_o,
  output logic [NIB_W-1:0]  rf_cmd_o,
  output logic [IDX_W-1:0]  rd_a_idx_o,
  input  logic [DATA_W-1:0] rd_a_data_i,
  output logic [IDX_W-1:0]  rd_b_idx_o,
  input  logic [DATA_W-1:0] rd_b_data_i,
  output logic              cond_o,
  output logic              running_o,
  output logic [NLAMP-1:0]  lamps_o
);
  localparam int LIDX_W = $clog2(NLAMP);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  dec_t              dec;
  logic              exec, hit, jump_take, halt_take, lamp_cur;
  logic              flag_q, flag_nxt, flag_en;
  logic [ADDR_W-1:0] pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  insn_seq_decode u_dec (
    .insn_i (imem_data_i),
    .dec_o  (dec)
  );

  assign rd_a_idx_o = dec.a_idx;
  assign rd_b_idx_o = dec.b_idx;

  insn_seq_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a_i   (rd_a_data_i),
    .b_i   (rd_b_data_i),
    .rel_i (dec.rel),
    .hit_o (hit)
  );

  assign exec      = running_o & ~start_i;
  assign jump_take = dec.jmp_any | (dec.jmp_set & flag_q) | (dec.jmp_clr & ~flag_q);
  assign halt_take = dec.halt_any | (dec.halt_rel & hit);

  insn_seq_pc u_pc (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (start_i),
    .exec_i  (exec),
    .jump_i  (jump_take),
    .tgt_i   (imem_data_i[ADDR_W-1:0]),
    .halt_i  (halt_take),
    .pc_o    (pc),
    .run_o   (running_o)
  );

  insn_seq_lamps #(.NLAMP(NLAMP), .LIDX_W(LIDX_W)) u_lamps (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sel_en_i  (exec & dec.lamp_sel),
    .sel_val_i (rd_a_data_i[LIDX_W-1:0]),
    .on_en_i   (exec & dec.lamp_on),
    .off_en_i  (exec & dec.lamp_off),
    .lamps_o   (lamps_o),
    .cur_o     (lamp_cur)
  );

  always_comb begin
    flag_en  = 1'b0;
    flag_nxt = flag_q;
    if (exec && dec.cmp_wr) begin
      flag_en  = 1'b1;
      flag_nxt = hit;
    end else if (exec && dec.lamp_test) begin
      flag_en  = 1'b1;
      flag_nxt = lamp_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_nxt;
  end

  assign cond_o      = flag_q;
  assign imem_addr_o = pc;
  assign alu_en_o    = exec & dec.alu_en;
  assign alu_fn_o    = imem_data_i[NIB_W-1:0];
  assign rf_en_o     = exec & dec.rf_en;
  assign rf_cmd_o    = imem_data_i[NIB_W-1:0];

  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({alu_en_o, rf_en_o})); // R3
  AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    !running_o |-> (!alu_en_o && !rf_en_o)); // R2
  AST_WAIT_STEPS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec && dec.is_wait) |=> (pc == $past(pc) + ADDR_W'(1)) && running_o); // R4
  AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec && jump_take) |=> pc == $past(imem_data_i[ADDR_W-1:0])); // R6
  AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(exec && (dec.cmp_wr || dec.lamp_test)) |=> $stable(cond_o)); // R7
endmodule

// File: tb/tb_insn_sequencer.sv
`timescale 1ns/100ps
module tb_insn_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  imem_addr_o;
  logic [11:0] imem_data_i;
  logic        alu_en_o, rf_en_o, cond_o, running_o;
  logic [3:0]  alu_fn_o, rf_cmd_o, rd_a_data_i, rd_b_data_i, lamps_o;
  logic [1:0]  rd_a_idx_o, rd_b_idx_o;

  logic [11:0] pm [256];
  logic [3:0]  rf [4];
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  assign imem_data_i = pm[imem_addr_o];
  assign rd_a_data_i = rf[rd_a_idx_o];
  assign rd_b_data_i = rf[rd_b_idx_o];

  insn_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .imem_addr_o(imem_addr_o), .imem_data_i(imem_data_i),
    .alu_en_o(alu_en_o), .alu_fn_o(alu_fn_o),
    .rf_en_o(rf_en_o), .rf_cmd_o(rf_cmd_o),
    .rd_a_idx_o(rd_a_idx_o), .rd_a_data_i(rd_a_data_i),
    .rd_b_idx_o(rd_b_idx_o), .rd_b_data_i(rd_b_data_i),
    .cond_o(cond_o), .running_o(running_o), .lamps_o(lamps_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) pm[i] = 12'h200;
  endtask

  task automatic kick();
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 pc", imem_addr_o, 0);
    chk("R1 running", running_o, 0);
    chk("R1 flag", cond_o, 0);
    chk("R1 lamps", lamps_o, 0);
    chk("R1 enables", {alu_en_o, rf_en_o}, 0);
    pm[0] = 12'h00A;
    repeat (3) step();
    chk("R2 halted pc holds", imem_addr_o, 0);
    chk("R2 halted no alu enable", alu_en_o, 0);
  endtask

  task automatic t_alu_rf();
    clear_prog();
    pm[0] = 12'h00A;
    pm[1] = 12'h10C;
    kick();
    chk("R2 start pc", imem_addr_o, 0);
    chk("R2 start run", running_o, 1);
    chk("R3 alu en", alu_en_o, 1);
    chk("R3 alu fn", alu_fn_o, 4'hA);
    chk("R3 rf en low", rf_en_o, 0);
    step();
    chk("R3 rf en", rf_en_o, 1);
    chk("R3 rf cmd", rf_cmd_o, 4'hC);
    chk("R3 alu en low", alu_en_o, 0);
  endtask

  task automatic t_compare();
    clear_prog();
    rf[0] = 4'hF; rf[1] = 4'h1; rf[2] = 4'h9; rf[3] = 4'h9;
    pm[0] = 12'h741;
    pm[1] = 12'h7E1;
    pm[2] = 12'h7E3;
    pm[3] = 12'h745;
    pm[4] = 12'h7E2;
    pm[5] = 12'h712;
    kick();
    step(); chk("R7 unsigned 15>1", cond_o, 1);
    step(); chk("R7 9>9", cond_o, 0);
    step(); chk("R7 9==9", cond_o, 1);
    step(); chk("R7 low nibble 5 keeps flag", cond_o, 1);
    step(); chk("R7 9<9", cond_o, 0);
    step(); chk("R7 packing 1<15", cond_o, 1);
  endtask

  task automatic t_nop();
    clear_prog();
    pm[0] = 12'h200;
    pm[1] = 12'h4FF;
    pm[2] = 12'hB12;
    pm[3] = 12'hD34;
    kick();
    for (int i = 0; i < 4; i++) begin
      chk("R4 no enable", {alu_en_o, rf_en_o}, 0);
      step();
    end
    chk("R4 pc advanced", imem_addr_o, 4);
    chk("R4 flag untouched", cond_o, 1);
    chk("R4 lamps untouched", lamps_o, 0);
    chk("R4 still running", running_o, 1);
  endtask

  task automatic t_jump();
    clear_prog();
    pm[0] = 12'h3FF;
    kick();
    step(); chk("R5 jump to ff", imem_addr_o, 8'hFF);
    step(); chk("R5 wrap to 0", imem_addr_o, 0);
  endtask

  task automatic t_cond_jump();
    clear_prog();
    rf[0] = 4'h5; rf[1] = 4'h3;
    pm[8'h00] = 12'h741;
    pm[8'h01] = 12'h510;
    pm[8'h10] = 12'h620;
    pm[8'h11] = 12'h742;
    pm[8'h12] = 12'h630;
    pm[8'h30] = 12'h540;
    kick();
    step(); chk("R7 5>3", cond_o, 1);
    step(); chk("R6 jump if set taken", imem_addr_o, 8'h10);
    step(); chk("R6 jump if clear skipped", imem_addr_o, 8'h11);
    step(); chk("R7 5<3", cond_o, 0);
    step(); chk("R6 jump if clear taken", imem_addr_o, 8'h30);
    step(); chk("R6 jump if set skipped", imem_addr_o, 8'h31);
  endtask

  task automatic t_halt();
    clear_prog();
    rf[0] = 4'h2; rf[1] = 4'h7;
    pm[0] = 12'h814;
    pm[1] = 12'h824;
    kick();
    step();
    chk("R8 gt false continues", imem_addr_o, 1);
    chk("R8 gt false running", running_o, 1);
    step();
    chk("R8 lt halts", running_o, 0);
    chk("R8 halt pc stays", imem_addr_o, 1);
    clear_prog();
    rf[1] = 4'h2;
    pm[0] = 12'h834;
    kick();
    step();
    chk("R8 eq halts", running_o, 0);
    clear_prog();
    pm[0] = 12'h800;
    pm[1] = 12'h005;
    kick();
    step();
    chk("R8 plain halt", running_o, 0);
    repeat (3) step();
    chk("R2 halted pc", imem_addr_o, 0);
    chk("R2 halted no enable", alu_en_o, 0);
  endtask

  task automatic t_lamps();
    clear_prog();
    rf[2] = 4'h3; rf[3] = 4'h6;
    pm[0] = 12'h920;
    pm[1] = 12'h940;
    pm[2] = 12'h960;
    pm[3] = 12'h930;
    pm[4] = 12'h940;
    pm[5] = 12'h950;
    pm[6] = 12'h960;
    kick();
    step();
    step(); chk("R9 lamp 3 on", lamps_o, 4'b1000);
    step(); chk("R9 test lit lamp", cond_o, 1);
    step();
    step(); chk("R9 lamp 2 on", lamps_o, 4'b1100);
    step(); chk("R9 lamp 2 off", lamps_o, 4'b1000);
    step(); chk("R9 test dark lamp", cond_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) rf[i] = 4'h0;
    clear_prog();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_alu_rf();
    t_compare();
    t_nop();
    t_jump();
    t_cond_jump();
    t_halt();
    t_lamps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule